// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block drives and samples a bank of general-purpose pins through a small word-addressed register bus. For each pin, software chooses the direction and the level to drive. It can also read back the pin level after that level has been brought into the clock domain. Any pin can serve as an interrupt source. Each source has its own trigger condition, an enable bit, a sticky status bit and a mask bit. All sources combine into a single request line.

Software clears status bits by writing ones to them. The mask has two write-one ports: one sets mask bits and one clears them. Because of this, no read-modify-write is needed. The trigger condition of each pin is a 3-bit code. These codes are packed four bits apart across two mode words. A soft-reset word returns every register to its power-on value while its control bit is held at 1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe`=0), `pin_out`=0, all mask bits are 1, enables, modes and status are 0, and `irq`=0.
- R2: Read data appears on `bus_rdata` one clock after the address is presented. The words at byte offsets 0x00 (enable), 0x18 (drive level), 0x20 (direction, 1 = output) and 0x38 (pin select) read back what was written, limited to the low 12 bits. `pin_out` and `pin_oe` follow the 0x18 and 0x20 words.
- R3: Word 0x1C returns the pin levels after a two-flop synchronizer. A change on `pin_in` shows up in a read issued three clocks later.
- R4: The trigger code of pin p (p<8) sits in bits 4p+2..4p of word 0x24. For pins 8 to 11 the code sits in bits 4(p-8)+2..4(p-8) of word 0x28. The fourth bit of each nibble, and every nibble that has no pin, reads 0.
- R5: For an enabled pin, code 0 sets its status bit on a 1-to-0 transition, code 1 on a 0-to-1 transition, and code 4 on either transition. The status is read at word 0x04.
- R6: Code 2 (level low) and code 3 (level high) set the status bit on every clock that the level is present. A clear while the level persists leaves the bit set. After the level goes away, a clear removes it.
- R7: Codes 5, 6 and 7 never set status. A pin whose enable bit is 0 never sets status.
- R8: Writing word 0x0C clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R9: Writing word 0x10 sets the mask bits written as 1. Writing word 0x14 clears the mask bits written as 1. Zero bits leave the mask unchanged. Word 0x10 reads the mask.
- R10: Word 0x08 reads status AND NOT mask. `irq` is 1 exactly when that value is nonzero.
- R11: Writing 1 to bit 0 of word 0x3C forces every register to its R1 value. The registers stay there, and other writes are ignored, until a 0 is written to the word. Word 0x3C reads back the bit.
- R12: Offsets 0x2C, 0x30 and 0x34, and the write-only words 0x0C and 0x14, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Levels to drive |
| pin_oe | output | 12 | Drive enables (1 = output) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 12 pins, a 6-bit byte address and a 32-bit data word. With these defaults the second mode word is only partly populated, so the unused nibbles in word 0x28 can be observed. The detection test covers all eight trigger codes against every pair of old and new levels, including the codes that must stay silent. It also exercises pins on both sides of the pin-7/pin-8 split between the mode words. Random data checks the readback of the writable words and the truncation of those words to 12 bits.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    // word indices (byte offset / 4)
    localparam int unsigned W_EN    = 0;
    localparam int unsigned W_STAT  = 1;
    localparam int unsigned W_VIEW  = 2;
    localparam int unsigned W_ACK   = 3;
    localparam int unsigned W_MSET  = 4;
    localparam int unsigned W_MCLR  = 5;
    localparam int unsigned W_DOUT  = 6;
    localparam int unsigned W_DIN   = 7;
    localparam int unsigned W_DIR   = 8;
    localparam int unsigned W_MODE0 = 9;
    localparam int unsigned W_MODE1 = 10;
    localparam int unsigned W_SEL   = 14;
    localparam int unsigned W_SRST  = 15;

    localparam int unsigned CODE_W       = 3;
    localparam int unsigned FIELD_STRIDE = 4;
    localparam int unsigned PINS_PER_REG = 8;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int unsigned NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] cur,
    output logic [NUM_PINS-1:0] prev
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] stable;
        logic [NUM_PINS-1:0] last;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.meta   = pin_in;
        sy_d.stable = sy_q.meta;
        sy_d.last   = sy_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign cur  = sy_q.stable;
    assign prev = sy_q.last;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12
) (
    input  logic [NUM_PINS-1:0]             cur,
    input  logic [NUM_PINS-1:0]             prev,
    input  logic [NUM_PINS-1:0][CODE_W-1:0] mode,
    output logic [NUM_PINS-1:0]             hit
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        always_comb begin
            case (trig_e'(mode[g]))
                TRIG_FALL: hit[g] = prev[g] & ~cur[g];
                TRIG_RISE: hit[g] = ~prev[g] & cur[g];
                TRIG_LOW:  hit[g] = ~cur[g];
                TRIG_HIGH: hit[g] = cur[g];
                TRIG_BOTH: hit[g] = prev[g] ^ cur[g];
                default:   hit[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [NUM_PINS-1:0]             en;
        logic [NUM_PINS-1:0]             stat;
        logic [NUM_PINS-1:0]             mask;
        logic [NUM_PINS-1:0]             dout;
        logic [NUM_PINS-1:0]             dir;
        logic [NUM_PINS-1:0]             sel;
        logic [NUM_PINS-1:0][CODE_W-1:0] mode;
        logic                            srst;
        logic [DATA_W-1:0]               rdata;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s      = '0;
        s.mask = '1;
        return s;
    endfunction

    state_t st_d, st_q;

    logic [WORD_W-1:0]   word_idx;
    logic [NUM_PINS-1:0] cur, prev, hit, ack, wbits;
    logic [DATA_W-1:0]   rd_v;
    logic                srst_wr;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign wbits    = bus_wdata[NUM_PINS-1:0];

    gpio_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .cur    (cur),
        .prev   (prev)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .cur  (cur),
        .prev (prev),
        .mode (st_q.mode),
        .hit  (hit)
    );

    always_comb begin
        st_d    = st_q;
        ack     = '0;
        srst_wr = bus_we && (word_idx == WORD_W'(W_SRST));

        if (bus_we && word_idx == WORD_W'(W_ACK)) ack = wbits;
        st_d.stat = (st_q.stat & ~ack) | (hit & st_q.en);

        if (bus_we) begin
            case (word_idx)
                WORD_W'(W_EN):   st_d.en   = wbits;
                WORD_W'(W_MSET): st_d.mask = st_q.mask | wbits;
                WORD_W'(W_MCLR): st_d.mask = st_q.mask & ~wbits;
                WORD_W'(W_DOUT): st_d.dout = wbits;
                WORD_W'(W_DIR):  st_d.dir  = wbits;
                WORD_W'(W_SEL):  st_d.sel  = wbits;
                WORD_W'(W_MODE0): begin
                    for (int i = 0; i < NUM_PINS; i++)
                        if (i < PINS_PER_REG)
                            st_d.mode[i] = bus_wdata[i*FIELD_STRIDE +: CODE_W];
                end
                WORD_W'(W_MODE1): begin
                    for (int i = 0; i < NUM_PINS; i++)
                        if (i >= PINS_PER_REG)
                            st_d.mode[i] = bus_wdata[(i-PINS_PER_REG)*FIELD_STRIDE +: CODE_W];
                end
                default: ;
            endcase
        end

        // soft reset: a 1 forces defaults, held until a 0 is written
        if (st_q.srst || (srst_wr && bus_wdata[0])) begin
            st_d      = reset_state();
            st_d.srst = !(srst_wr && !bus_wdata[0]);
        end

        rd_v = '0;
        case (word_idx)
            WORD_W'(W_EN):   rd_v = DATA_W'(st_q.en);
            WORD_W'(W_STAT): rd_v = DATA_W'(st_q.stat);
            WORD_W'(W_VIEW): rd_v = DATA_W'(st_q.stat & ~st_q.mask);
            WORD_W'(W_MSET): rd_v = DATA_W'(st_q.mask);
            WORD_W'(W_DOUT): rd_v = DATA_W'(st_q.dout);
            WORD_W'(W_DIN):  rd_v = DATA_W'(cur);
            WORD_W'(W_DIR):  rd_v = DATA_W'(st_q.dir);
            WORD_W'(W_SEL):  rd_v = DATA_W'(st_q.sel);
            WORD_W'(W_SRST): rd_v = DATA_W'(st_q.srst);
            WORD_W'(W_MODE0): begin
                for (int i = 0; i < NUM_PINS; i++)
                    if (i < PINS_PER_REG)
                        rd_v[i*FIELD_STRIDE +: CODE_W] = st_q.mode[i];
            end
            WORD_W'(W_MODE1): begin
                for (int i = 0; i < NUM_PINS; i++)
                    if (i >= PINS_PER_REG)
                        rd_v[(i-PINS_PER_REG)*FIELD_STRIDE +: CODE_W] = st_q.mode[i];
            end
            default: rd_v = '0;
        endcase
        st_d.rdata = rd_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pin_out   = st_q.dout;
    assign pin_oe    = st_q.dir;
    assign irq       = |(st_q.stat & ~st_q.mask);

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    // R2: drive-level word read returns last cycle's register one clock later
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(W_DOUT * 4)) |=> (bus_rdata == DATA_W'($past(st_q.dout))));

    // R7: a status bit can only rise on a pin that was enabled
    assert_no_set_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.stat & ~$past(st_q.stat) & ~$past(st_q.en)) == '0));

    // R9: ones written to the mask-clear word leave those bits unmasked
    assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word_idx == WORD_W'(W_MCLR) && !st_q.srst)
        |=> ((st_q.mask & $past(wbits)) == '0));

    // R10: a request needs a latched status bit behind it
    assert_irq_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|st_q.stat));

    // R11: while soft reset is held, configuration sits at defaults
    assert_soft_reset_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.srst |-> (st_q.en == '0 && st_q.stat == '0 && st_q.mask == '1
                       && st_q.dir == '0 && st_q.dout == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
    localparam int N = 12;
    localparam logic [5:0] A_EN = 6'h00, A_STAT = 6'h04, A_VIEW = 6'h08, A_ACK = 6'h0C,
                           A_MSET = 6'h10, A_MCLR = 6'h14, A_DOUT = 6'h18, A_DIN = 6'h1C,
                           A_DIR = 6'h20, A_MODE0 = 6'h24, A_MODE1 = 6'h28, A_SEL = 6'h38,
                           A_SRST = 6'h3C;
    localparam logic [31:0] PMASK = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk);
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic bit exp_hit(input int code, input bit o, input bit n);
        case (code)
            0: return o && !n;
            1: return !o && n;
            2: return !o || !n;
            3: return o || n;
            4: return o != n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [5:0] mode_addr(input int pin);
        return (pin < 8) ? A_MODE0 : A_MODE1;
    endfunction

    function automatic logic [31:0] mode_word(input int pin, input int code);
        int p = (pin < 8) ? pin : pin - 8;
        return 32'(code) << (4 * p);
    endfunction

    task automatic edge_case(input string tag, input int pin, input int code, input bit o, input bit n);
        logic [31:0] v;
        wr(A_EN, 0);
        wr(A_MODE0, 0);
        wr(A_MODE1, 0);
        @(negedge clk); pin_in[pin] = o;
        idle(5);
        wr(mode_addr(pin), mode_word(pin, code));
        wr(A_EN, 32'(1) << pin);
        wr(A_ACK, PMASK);
        @(negedge clk); pin_in[pin] = n;
        idle(5);
        rd(A_STAT, v);
        check(tag, v, exp_hit(code, o, n) ? (32'(1) << pin) : 32'h0);
        wr(A_EN, 0);
        wr(A_ACK, PMASK);
    endtask

    initial begin
        logic [31:0] v, r;
        void'($urandom(32'h1A2B3C4D));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 0);
        check("R1 pin_out", 32'(pin_out), 0);
        check("R1 irq", 32'(irq), 0);
        rd(A_MSET, v);  check("R1 mask", v, PMASK);
        rd(A_EN, v);    check("R1 enable", v, 0);
        rd(A_STAT, v);  check("R1 status", v, 0);
        rd(A_MODE0, v); check("R1 mode0", v, 0);

        // R2 random readback, truncated to 12 bits
        for (int k = 0; k < 24; k++) begin
            logic [5:0] a;
            r = $urandom;
            case (k % 4)
                0: a = A_EN;
                1: a = A_DOUT;
                2: a = A_DIR;
                default: a = A_SEL;
            endcase
            wr(a, r);
            rd(a, v);
            check("R2 readback", v, r & PMASK);
            if (a == A_DOUT) check("R2 pin_out port", 32'(pin_out), r & PMASK);
            if (a == A_DIR)  check("R2 pin_oe port", 32'(pin_oe), r & PMASK);
        end
        wr(A_EN, 0);
        wr(A_ACK, PMASK);

        // R3 synchronized input
        for (int k = 0; k < 6; k++) begin
            r = $urandom & PMASK;
            @(negedge clk); pin_in = r[N-1:0];
            idle(2);
            rd(A_DIN, v);
            check("R3 input sample", v, r);
        end

        // R4 field packing
        wr(A_MODE0, 32'hFFFF_FFFF);
        rd(A_MODE0, v); check("R4 mode0 fields", v, 32'h7777_7777);
        wr(A_MODE1, 32'hFFFF_FFFF);
        rd(A_MODE1, v); check("R4 mode1 fields", v, 32'h0000_7777);
        wr(A_MODE1, 32'h0000_0250);
        rd(A_MODE1, v); check("R4 mode1 pin9", v, 32'h0000_0250);

        // R5 R6 R7 exhaustive code x transition, pins on both sides of split
        for (int c = 0; c < 8; c++)
            for (int t = 0; t < 4; t++) begin
                int p = (c * 4 + t) % N;
                string tag = (c < 2 || c == 4) ? "R5 edge" : ((c < 4) ? "R6 level" : "R7 silent code");
                edge_case(tag, p, c, t[1], t[0]);
            end
        for (int k = 0; k < 16; k++)
            edge_case("R5 random detect", $urandom_range(0, N - 1), $urandom_range(0, 7),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R7 disabled pin: toggle with rising code, enable off
        wr(A_MODE0, 32'h0000_0001);
        @(negedge clk); pin_in[0] = 1'b0; idle(4);
        wr(A_ACK, PMASK);
        @(negedge clk); pin_in[0] = 1'b1; idle(5);
        rd(A_STAT, v); check("R7 disabled pin", v, 0);

        // R6 level persists through clear, then clears
        wr(A_MODE0, 32'h0030_0000);
        @(negedge clk); pin_in[5] = 1'b1; idle(4);
        wr(A_EN, 32'h020);
        idle(2);
        wr(A_ACK, 32'h020);
        rd(A_STAT, v); check("R6 level survives clear", v, 32'h020);
        @(negedge clk); pin_in[5] = 1'b0; idle(4);
        wr(A_ACK, 32'h020);
        rd(A_STAT, v); check("R6 clear after level gone", v, 0);
        wr(A_EN, 0);

        // R8 selective clear
        wr(A_MODE0, 32'h0000_0110);
        @(negedge clk); pin_in[2:1] = 2'b00; idle(4);
        wr(A_EN, 32'h006);
        wr(A_ACK, PMASK);
        @(negedge clk); pin_in[2:1] = 2'b11; idle(5);
        wr(A_ACK, 32'h002);
        rd(A_STAT, v); check("R8 selective clear", v, 32'h004);

        // R9 R10 mask and combined request
        check("R10 irq masked", 32'(irq), 0);
        rd(A_VIEW, v); check("R10 view masked", v, 0);
        wr(A_MCLR, 32'h004);
        check("R10 irq unmasked", 32'(irq), 1);
        rd(A_VIEW, v); check("R10 view", v, 32'h004);
        rd(A_MSET, v); check("R9 mask after clear", v, 32'hFFB);
        wr(A_MSET, 32'h000);
        rd(A_MSET, v); check("R9 zero bits keep mask", v, 32'hFFB);
        wr(A_MSET, 32'h004);
        check("R9 irq after set", 32'(irq), 0);
        wr(A_EN, 0);

        // R12 reserved and write-only offsets
        rd(6'h2C, v); check("R12 reserved 2C", v, 0);
        rd(6'h30, v); check("R12 reserved 30", v, 0);
        rd(6'h34, v); check("R12 reserved 34", v, 0);
        rd(A_ACK, v); check("R12 ack reads 0", v, 0);
        rd(A_MCLR, v); check("R12 mclr reads 0", v, 0);

        // R11 soft reset
        wr(A_EN, 32'hABC); wr(A_DOUT, 32'h5A5); wr(A_DIR, 32'hF0F); wr(A_MCLR, PMASK);
        wr(A_SRST, 1);
        rd(A_SRST, v); check("R11 reset bit reads 1", v, 1);
        wr(A_EN, 32'hFFF);
        wr(A_SRST, 0);
        rd(A_EN, v);   check("R11 enable default", v, 0);
        rd(A_MSET, v); check("R11 mask default", v, PMASK);
        rd(A_DOUT, v); check("R11 drive default", v, 0);
        rd(A_SRST, v); check("R11 reset bit released", v, 0);
        check("R11 pin_oe default", 32'(pin_oe), 0);
        wr(A_EN, 32'h00F);
        rd(A_EN, v); check("R11 writes resume", v, 32'h00F);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule